// File: doc/BRIEF.md
# Landing Pad Checker

This unit enforces forward-edge control-flow protection for a small 32-bit in-order RISC-V core. It holds one bit of state, the expected-landing-pad flag. An indirect jump or call that retires while landing pads are enabled at the current privilege level sets the flag. The next instruction that retires must then be a landing-pad instruction whose label agrees with the tag the caller placed in the upper bits of x7. If it is not, the unit raises a software-check fault with its cause and trap value.

The flag survives traps and returns. When a trap is taken, the flag is copied into a supervisor-side or machine-side saved bit and then cleared. A return restores the flag from the matching saved bit, but only when landing pads are enabled at the privilege level being returned to. The unit also reports whether the retiring word is an ordinary AUIPC, because a landing pad shares that major opcode. The surrounding core supplies retire information, privilege, the three per-level enable bits, the x7 tag and trap/return events. It consumes the fault pulse and the saved bits.

Top module: `lp_guard`

## Requirements
- R1: After a synchronous reset, `elp`, `spelp`, `mpelp` and `swchk_fault` are 0, and `swchk_cause` and `swchk_tval` are 0.
- R2: A word is a landing pad when bits [6:0] equal 7'b0010111 and bits [11:7] (rd) are 0; its label is bits [31:12]. `auipc_op` is combinationally 1 for opcode 7'b0010111 with rd not 0, and 0 for landing pads and every other opcode.
- R3: The landing-pad enable follows `priv` (2'd3 machine, 2'd1 supervisor, 2'd0 user). Machine mode uses `cfg_m_lpe`, supervisor mode uses `cfg_s_lpe`, and user mode uses `cfg_u_lpe`. Encoding 2'd2 is never enabled.
- R4: A JALR (opcode 7'b1100111, funct3 0) retires while `elp` is 0. If its rs1 (bits [19:15]) is neither 1 nor 5 and the current level is enabled, `elp` is 1 on the next cycle. If rs1 is 1 or 5, or the level is disabled, `elp` stays 0.
- R5: A landing pad retires while `elp` is 1. If its label is zero or equals `x7_tag`, `elp` is 0 on the next cycle and no fault is raised.
- R6: Any other instruction retires while `elp` is 1. This includes a landing pad whose label is non-zero and differs from `x7_tag`. `swchk_fault` is then 1 for exactly the next cycle, with `swchk_cause` = 18 and `swchk_tval` = 2. `elp` keeps its value.
- R7: A landing pad that retires while `elp` is 0 has no effect: `elp` stays 0 and no fault is raised.
- R8: On `trap_valid`, `elp` is copied into `spelp` when `trap_to_s` is 1, or into `mpelp` otherwise; the other saved bit is unchanged. `elp` is 0 on the next cycle.
- R9: On `mret_valid`, `elp` becomes `mpelp` if landing pads are enabled at `xret_priv` (per R3), else 0. `mpelp` becomes 0.
- R10: On `sret_valid`, `elp` becomes `spelp` if landing pads are enabled at `xret_priv`, else 0. `spelp` becomes 0.
- R11: Events in the same cycle resolve in this order: a trap, then a machine return, then a supervisor return, then a retire. A lower-priority event has no effect in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| priv | input | 2 | Current privilege level |
| cfg_m_lpe | input | 1 | Landing-pad enable for machine mode (security config bit 10) |
| cfg_s_lpe | input | 1 | Landing-pad enable for supervisor mode (machine env config bit 2) |
| cfg_u_lpe | input | 1 | Landing-pad enable for user mode (supervisor env config bit 2) |
| x7_tag | input | 20 | Bits [31:12] of register x7 |
| retire_valid | input | 1 | An instruction retires this cycle |
| retire_instr | input | 32 | Encoding of the retiring instruction |
| trap_valid | input | 1 | A trap is taken this cycle |
| trap_to_s | input | 1 | The trap is delegated to supervisor |
| mret_valid | input | 1 | A machine return executes |
| sret_valid | input | 1 | A supervisor return executes |
| xret_priv | input | 2 | Privilege level the return goes to |
| elp | output | 1 | Expected-landing-pad flag |
| spelp | output | 1 | Flag saved by supervisor traps |
| mpelp | output | 1 | Flag saved by machine traps |
| auipc_op | output | 1 | Retiring word is an ordinary AUIPC |
| swchk_fault | output | 1 | Software-check fault pulse |
| swchk_cause | output | 32 | Exception cause while faulting, else 0 |
| swchk_tval | output | 32 | Fault code while faulting, else 0 |

## Verification
`auipc_op` is combinational and is checked in the same cycle the word is driven. Every other output is registered: a retire, trap or return driven before a rising edge shows its result on `elp`, `spelp`, `mpelp` and the fault outputs right after that edge. The bench drives inputs just after a falling edge and samples at the following falling edge. Each check is therefore one edge after the stimulus. The fault-pulse check samples one edge later again to see that the fault has dropped.

// File: rtl/lpg_pkg.sv
package lpg_pkg;
  typedef enum logic [1:0] {
    PRIV_U   = 2'd0,
    PRIV_S   = 2'd1,
    PRIV_RSV = 2'd2,
    PRIV_M   = 2'd3
  } priv_e;

  localparam logic [6:0] OPC_AUIPC = 7'b0010111;
  localparam logic [6:0] OPC_JALR  = 7'b1100111;
  localparam logic [4:0] REG_RA    = 5'd1;
  localparam logic [4:0] REG_T0    = 5'd5;
endpackage

// File: rtl/lpg_decode.sv
module lpg_decode
  import lpg_pkg::*;
#(
  parameter int ILEN    = 32,
  parameter int LABEL_W = 20
) (
  input  logic [ILEN-1:0]    instr,
  output logic               is_lpad,
  output logic               is_auipc,
  output logic               is_fwd_jump,
  output logic [LABEL_W-1:0] label
);
  logic [6:0] opc;
  logic [4:0] rd_f;
  logic [4:0] rs1_f;
  logic [2:0] f3;
  logic       jalr_hit;
  logic       link_src;

  assign opc   = instr[6:0];
  assign rd_f  = instr[11:7];
  assign f3    = instr[14:12];
  assign rs1_f = instr[19:15];
  assign label = instr[ILEN-1:ILEN-LABEL_W];

  // landing pad shares the AUIPC opcode, distinguished by rd == x0
  assign is_lpad  = (opc == OPC_AUIPC) && (rd_f == 5'd0);
  assign is_auipc = (opc == OPC_AUIPC) && !is_lpad;

  // a JALR through the link registers is a return, not a forward edge
  assign jalr_hit    = (opc == OPC_JALR) && (f3 == 3'b000);
  assign link_src    = (rs1_f == REG_RA) || (rs1_f == REG_T0);
  assign is_fwd_jump = jalr_hit && !link_src;

  always_comb begin
    assert_decode_exclusive_R2: assert (!(is_lpad && is_auipc) && !(is_lpad && is_fwd_jump));
  end
endmodule

// File: rtl/lpg_enable.sv
module lpg_enable
  import lpg_pkg::*;
(
  input  logic [1:0] priv,
  input  logic       m_en,
  input  logic       s_en,
  input  logic       u_en,
  output logic       lp_en
);
  always_comb begin
    unique case (priv_e'(priv))
      PRIV_M:  lp_en = m_en;
      PRIV_S:  lp_en = s_en;
      PRIV_U:  lp_en = u_en;
      default: lp_en = 1'b0;
    endcase
  end
endmodule

// File: rtl/lpg_state.sv
module lpg_state #(
  parameter int LABEL_W    = 20,
  parameter int XLEN       = 32,
  parameter int CAUSE_CODE = 18,
  parameter int FAULT_CODE = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               retire_valid,
  input  logic               is_lpad,
  input  logic               is_fwd_jump,
  input  logic [LABEL_W-1:0] label,
  input  logic [LABEL_W-1:0] x7_tag,
  input  logic               cur_en,
  input  logic               ret_en,
  input  logic               trap_valid,
  input  logic               trap_to_s,
  input  logic               mret_valid,
  input  logic               sret_valid,
  output logic               elp_q,
  output logic               spelp_q,
  output logic               mpelp_q,
  output logic               fault_q,
  output logic [XLEN-1:0]    cause,
  output logic [XLEN-1:0]    tval
);
  localparam logic [XLEN-1:0] CAUSE_V = XLEN'(CAUSE_CODE);
  localparam logic [XLEN-1:0] TVAL_V  = XLEN'(FAULT_CODE);

  logic label_ok;
  logic pad_ok;
  logic quiet;

  assign label_ok = (label == '0) || (label == x7_tag);
  assign pad_ok   = is_lpad && label_ok;
  assign quiet    = !trap_valid && !mret_valid && !sret_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      elp_q   <= 1'b0;
      spelp_q <= 1'b0;
      mpelp_q <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      fault_q <= 1'b0;
      if (trap_valid) begin
        if (trap_to_s) spelp_q <= elp_q;
        else           mpelp_q <= elp_q;
        elp_q <= 1'b0;
      end else if (mret_valid) begin
        elp_q   <= ret_en ? mpelp_q : 1'b0;
        mpelp_q <= 1'b0;
      end else if (sret_valid) begin
        elp_q   <= ret_en ? spelp_q : 1'b0;
        spelp_q <= 1'b0;
      end else if (retire_valid) begin
        if (elp_q) begin
          if (pad_ok) elp_q   <= 1'b0;
          else        fault_q <= 1'b1;
        end else if (is_fwd_jump && cur_en) begin
          elp_q <= 1'b1;
        end
      end
    end
  end

  assign cause = fault_q ? CAUSE_V : '0;
  assign tval  = fault_q ? TVAL_V  : '0;

  assert_trap_clears_R8: assert property (@(posedge clk) disable iff (rst)
    trap_valid |=> !elp_q);
  assert_mret_gated_R9: assert property (@(posedge clk) disable iff (rst)
    (!trap_valid && mret_valid && !ret_en) |=> (!elp_q && !mpelp_q));
  assert_sret_gated_R10: assert property (@(posedge clk) disable iff (rst)
    (!trap_valid && !mret_valid && sret_valid && !ret_en) |=> (!elp_q && !spelp_q));
  assert_fault_needs_elp_R6: assert property (@(posedge clk) disable iff (rst)
    fault_q |-> ($past(elp_q) && $past(retire_valid)));
  assert_pad_clears_R5: assert property (@(posedge clk) disable iff (rst)
    (quiet && retire_valid && elp_q && pad_ok) |=> (!elp_q && !fault_q));
  assert_return_no_set_R4: assert property (@(posedge clk) disable iff (rst)
    (quiet && retire_valid && !elp_q && !is_fwd_jump) |=> !elp_q);
endmodule

// File: rtl/lp_guard.sv
module lp_guard #(
  parameter int ILEN       = 32,
  parameter int XLEN       = 32,
  parameter int LABEL_W    = 20,
  parameter int CAUSE_CODE = 18,
  parameter int FAULT_CODE = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         priv,
  input  logic               cfg_m_lpe,
  input  logic               cfg_s_lpe,
  input  logic               cfg_u_lpe,
  input  logic [LABEL_W-1:0] x7_tag,
  input  logic               retire_valid,
  input  logic [ILEN-1:0]    retire_instr,
  input  logic               trap_valid,
  input  logic               trap_to_s,
  input  logic               mret_valid,
  input  logic               sret_valid,
  input  logic [1:0]         xret_priv,
  output logic               elp,
  output logic               spelp,
  output logic               mpelp,
  output logic               auipc_op,
  output logic               swchk_fault,
  output logic [XLEN-1:0]    swchk_cause,
  output logic [XLEN-1:0]    swchk_tval
);
  logic               d_lpad;
  logic               d_fwd;
  logic [LABEL_W-1:0] d_label;
  logic               en_now;
  logic               en_ret;

  lpg_decode #(.ILEN(ILEN), .LABEL_W(LABEL_W)) u_dec (
    .instr       (retire_instr),
    .is_lpad     (d_lpad),
    .is_auipc    (auipc_op),
    .is_fwd_jump (d_fwd),
    .label       (d_label)
  );

  lpg_enable u_en_now (
    .priv  (priv),
    .m_en  (cfg_m_lpe),
    .s_en  (cfg_s_lpe),
    .u_en  (cfg_u_lpe),
    .lp_en (en_now)
  );

  lpg_enable u_en_ret (
    .priv  (xret_priv),
    .m_en  (cfg_m_lpe),
    .s_en  (cfg_s_lpe),
    .u_en  (cfg_u_lpe),
    .lp_en (en_ret)
  );

  lpg_state #(
    .LABEL_W(LABEL_W), .XLEN(XLEN),
    .CAUSE_CODE(CAUSE_CODE), .FAULT_CODE(FAULT_CODE)
  ) u_st (
    .clk          (clk),
    .rst          (rst),
    .retire_valid (retire_valid),
    .is_lpad      (d_lpad),
    .is_fwd_jump  (d_fwd),
    .label        (d_label),
    .x7_tag       (x7_tag),
    .cur_en       (en_now),
    .ret_en       (en_ret),
    .trap_valid   (trap_valid),
    .trap_to_s    (trap_to_s),
    .mret_valid   (mret_valid),
    .sret_valid   (sret_valid),
    .elp_q        (elp),
    .spelp_q      (spelp),
    .mpelp_q      (mpelp),
    .fault_q      (swchk_fault),
    .cause        (swchk_cause),
    .tval         (swchk_tval)
  );

  assert_disabled_level_R3: assert property (@(posedge clk) disable iff (rst)
    (!elp && retire_valid && !en_now) |=> !elp || $past(trap_valid || mret_valid || sret_valid));
endmodule

// File: tb/lp_guard_test.sv
module lp_guard_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  priv;
  logic        cfg_m_lpe, cfg_s_lpe, cfg_u_lpe;
  logic [19:0] x7_tag;
  logic        retire_valid;
  logic [31:0] retire_instr;
  logic        trap_valid, trap_to_s, mret_valid, sret_valid;
  logic [1:0]  xret_priv;
  logic        elp, spelp, mpelp, auipc_op, swchk_fault;
  logic [31:0] swchk_cause, swchk_tval;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lp_guard uut (
    .clk(clk), .rst(rst), .priv(priv),
    .cfg_m_lpe(cfg_m_lpe), .cfg_s_lpe(cfg_s_lpe), .cfg_u_lpe(cfg_u_lpe),
    .x7_tag(x7_tag), .retire_valid(retire_valid), .retire_instr(retire_instr),
    .trap_valid(trap_valid), .trap_to_s(trap_to_s),
    .mret_valid(mret_valid), .sret_valid(sret_valid), .xret_priv(xret_priv),
    .elp(elp), .spelp(spelp), .mpelp(mpelp), .auipc_op(auipc_op),
    .swchk_fault(swchk_fault), .swchk_cause(swchk_cause), .swchk_tval(swchk_tval)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic en_of(input logic [1:0] p, input logic [2:0] cfg);
    case (p)
      2'd3: return cfg[2];
      2'd1: return cfg[1];
      2'd0: return cfg[0];
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] jalr_w(input logic [4:0] rs);
    return {12'h000, rs, 3'b000, 5'd0, 7'b1100111};
  endfunction

  function automatic logic [31:0] lpad_w(input logic [19:0] lab);
    return {lab, 5'd0, 7'b0010111};
  endfunction

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_cfg(input logic [2:0] cfg);
    {cfg_m_lpe, cfg_s_lpe, cfg_u_lpe} = cfg;
  endtask

  task automatic do_reset;
    rst = 1'b1; retire_valid = 0; trap_valid = 0; mret_valid = 0; sret_valid = 0;
    trap_to_s = 0; retire_instr = 32'h00000013; xret_priv = 2'd0;
    tick; tick;
    rst = 1'b0;
  endtask

  task automatic retire(input logic [31:0] w);
    retire_valid = 1'b1; retire_instr = w;
    tick;
    retire_valid = 1'b0; retire_instr = 32'h00000013;
  endtask

  task automatic arm_in_m;
    priv = 2'd3; set_cfg(3'b100);
    retire(jalr_w(5'd6));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    priv = 2'd3; set_cfg(3'b000); x7_tag = '0;
    @(negedge clk);
    do_reset;
    // R1 reset state
    chk("R1 elp", {31'd0, elp}, 0);
    chk("R1 spelp", {31'd0, spelp}, 0);
    chk("R1 mpelp", {31'd0, mpelp}, 0);
    chk("R1 fault", {31'd0, swchk_fault}, 0);
    chk("R1 cause", swchk_cause, 0);
    chk("R1 tval", swchk_tval, 0);

    // R2 decode sweep over rd for the AUIPC opcode, and other opcodes
    for (int rd = 0; rd < 32; rd++) begin
      retire_instr = {20'h5A5A5, 5'(rd), 7'b0010111};
      #1;
      chk("R2 auipc_op rd sweep", {31'd0, auipc_op}, (rd != 0) ? 1 : 0);
    end
    retire_instr = 32'h00100093; #1;
    chk("R2 addi not auipc", {31'd0, auipc_op}, 0);
    retire_instr = jalr_w(5'd6); #1;
    chk("R2 jalr not auipc", {31'd0, auipc_op}, 0);
    retire_instr = 32'h00000013;

    // R3 / R4 sweep: privilege x enables x rs1
    for (int p = 0; p < 4; p++) begin
      for (int c = 0; c < 8; c++) begin
        for (int k = 0; k < 4; k++) begin
          logic [4:0] rs;
          logic expv;
          rs = (k == 0) ? 5'd1 : (k == 1) ? 5'd5 : (k == 2) ? 5'd6 : 5'd0;
          do_reset;
          priv = 2'(p); set_cfg(3'(c));
          retire(jalr_w(rs));
          expv = (rs != 5'd1) && (rs != 5'd5) && en_of(2'(p), 3'(c));
          chk("R3 R4 jalr sets elp", {31'd0, elp}, {31'd0, expv});
        end
      end
    end

    // R5 / R6: landing pad matching with elp set
    for (int t = 0; t < 2; t++) begin
      for (int v = 0; v < 5; v++) begin
        logic [19:0] tag;
        logic [31:0] w;
        logic ok;
        tag = (t == 0) ? 20'h00000 : 20'hABCDE;
        case (v)
          0: begin w = lpad_w(20'h00000); ok = 1; end
          1: begin w = lpad_w(20'hABCDE); ok = (tag == 20'hABCDE); end
          2: begin w = lpad_w(20'h12345); ok = 0; end
          3: begin w = 32'h00100093;      ok = 0; end
          default: begin w = {20'hABCDE, 5'd1, 7'b0010111}; ok = 0; end
        endcase
        do_reset;
        x7_tag = tag;
        arm_in_m;
        chk("R4 armed", {31'd0, elp}, 1);
        retire(w);
        if (ok) begin
          chk("R5 elp cleared", {31'd0, elp}, 0);
          chk("R5 no fault", {31'd0, swchk_fault}, 0);
        end else begin
          chk("R6 elp held", {31'd0, elp}, 1);
          chk("R6 fault", {31'd0, swchk_fault}, 1);
          chk("R6 cause", swchk_cause, 32'd18);
          chk("R6 tval", swchk_tval, 32'd2);
          tick;
          chk("R6 single pulse", {31'd0, swchk_fault}, 0);
          chk("R6 cause idle", swchk_cause, 0);
        end
      end
    end

    // R7: landing pad without expectation
    do_reset;
    priv = 2'd3; set_cfg(3'b100); x7_tag = 20'h11111;
    retire(lpad_w(20'h22222));
    chk("R7 elp stays 0", {31'd0, elp}, 0);
    chk("R7 no fault", {31'd0, swchk_fault}, 0);

    // R8: trap save
    for (int e = 0; e < 2; e++) begin
      for (int d = 0; d < 2; d++) begin
        do_reset;
        if (e == 1) arm_in_m;
        trap_valid = 1; trap_to_s = d[0];
        tick;
        trap_valid = 0; trap_to_s = 0;
        chk("R8 elp cleared", {31'd0, elp}, 0);
        chk("R8 spelp", {31'd0, spelp}, {31'd0, (e == 1) && (d == 1)});
        chk("R8 mpelp", {31'd0, mpelp}, {31'd0, (e == 1) && (d == 0)});
      end
    end

    // R9 / R10: returns gated by target level enable
    for (int s = 0; s < 2; s++) begin
      for (int tp = 0; tp < 4; tp++) begin
        for (int c = 0; c < 8; c++) begin
          do_reset;
          arm_in_m;
          trap_valid = 1; trap_to_s = s[0];
          tick;
          trap_valid = 0; trap_to_s = 0;
          set_cfg(3'(c)); xret_priv = 2'(tp);
          if (s == 0) mret_valid = 1; else sret_valid = 1;
          tick;
          mret_valid = 0; sret_valid = 0;
          if (s == 0) begin
            chk("R9 elp restore", {31'd0, elp}, {31'd0, en_of(2'(tp), 3'(c))});
            chk("R9 mpelp cleared", {31'd0, mpelp}, 0);
          end else begin
            chk("R10 elp restore", {31'd0, elp}, {31'd0, en_of(2'(tp), 3'(c))});
            chk("R10 spelp cleared", {31'd0, spelp}, 0);
          end
        end
      end
    end

    // R11: trap beats a faulting retire in the same cycle
    do_reset;
    arm_in_m;
    trap_valid = 1; retire_valid = 1; retire_instr = 32'h00100093;
    tick;
    trap_valid = 0; retire_valid = 0;
    chk("R11 trap wins no fault", {31'd0, swchk_fault}, 0);
    chk("R11 trap wins elp", {31'd0, elp}, 0);
    chk("R11 trap wins mpelp", {31'd0, mpelp}, 1);
    // R11: machine return beats a forward jump; return to disabled level
    set_cfg(3'b100); xret_priv = 2'd0;
    mret_valid = 1; retire_valid = 1; retire_instr = jalr_w(5'd6);
    tick;
    mret_valid = 0; retire_valid = 0;
    chk("R11 mret wins elp", {31'd0, elp}, 0);
    // R11: machine return beats supervisor return
    do_reset;
    arm_in_m;
    trap_valid = 1; trap_to_s = 1;
    tick;
    trap_valid = 0; trap_to_s = 0;
    xret_priv = 2'd3;
    mret_valid = 1; sret_valid = 1;
    tick;
    mret_valid = 0; sret_valid = 0;
    chk("R11 mret over sret elp", {31'd0, elp}, 0);
    chk("R11 mret over sret spelp", {31'd0, spelp}, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule